// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the addressing layer of a single-wire bus slave. It sits between a bit-level slot engine and the function-command layer. The slot engine reports three kinds of events: a bus reset, a completed master write slot carrying one bit, and a completed read slot. From these events the block decides whether the function layer may be reached in the current transaction. It holds a 64-bit identity built from two parameters, a family code and a serial number. The identity's check byte is computed when the design is elaborated.

After every bus reset the block collects one command byte, least significant bit first. It then runs one of five behaviours:

- stream its identity;
- compare the identity against one supplied by the master;
- skip addressing;
- run the bitwise binary search used for enumeration;
- run the same search only when the alarm input is set.

When addressing succeeds, the block raises a grant that lasts until the next bus reset. When addressing fails, the block releases the bus for the rest of the transaction. For each read slot the block offers a valid flag and a bit. When the flag is low, the slot engine leaves the line released, so the master reads a 1.

Top module: `owr_rom_layer`

## Requirements
- R1: The identity is 64 bits. Bits 7:0 hold the family code (10h by default). Bits 55:8 hold the serial number. Bits 63:56 hold a CRC of bits 55:0. The CRC uses polynomial x^8+x^5+x^4+1, bits are fed in from bit 0 upward, and the register starts at zero.
- R2: After rst_n, and until the first bus reset, the block ignores write and read events. tx_valid_o and grant_o both stay 0.
- R3: Command 33h sends the 64 identity bits, bit 0 first, one per read slot, with tx_valid_o high. After the 64th slot, grant_o rises.
- R4: Command 55h takes 64 written bits, bit 0 first. If all 64 equal the identity, grant_o goes to 1.
- R5: After command 55h, the first written bit that differs from the identity makes the block quiet: grant_o 0 and tx_valid_o 0 until the next bus reset.
- R6: Command CCh raises grant_o in the cycle after the eighth command bit, with no address exchange. grant_o and tx_valid_o are never high together.
- R7: Command F0h runs 64 rounds. Each round offers the identity bit in one read slot, then its complement in the next read slot, then takes the master's direction bit from a write slot. After the last round the block is quiet and grant_o stays 0.
- R8: During a search, a direction bit that differs from the identity bit makes the block quiet until the next bus reset.
- R9: Command ECh behaves as F0h when alarm_i is 1 at the eighth command bit. Otherwise the block is quiet.
- R10: Any other command byte makes the block quiet until the next bus reset.
- R11: A bus reset in any state clears grant_o and tx_valid_o in the next cycle. It also restarts command reception.
- R12: While a bit is offered, write events do not advance the offer. The same bit stays on tx_bit_o until a read slot completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | One-cycle pulse: a reset/presence sequence has occurred on the line |
| wr_valid_i | input | 1 | One-cycle pulse: a master write slot has completed |
| wr_bit_i | input | 1 | Bit value of the completed write slot |
| rd_done_i | input | 1 | One-cycle pulse: a read slot has completed |
| alarm_i | input | 1 | Alarm flag from the function layer |
| tx_valid_o | output | 1 | The block drives the next read slot |
| tx_bit_o | output | 1 | Bit value for the next read slot |
| grant_o | output | 1 | Function-command access granted for this transaction |

## Verification
A wrong bit index or a corrupted check byte shows directly in the read and search slots. Each bit reaches tx_bit_o one cycle after the slot event that selects it, so a bench sees the fault within the 64-slot stream. A state machine that fails to leave an addressing state shows as tx_valid_o staying high, or grant_o rising, after a mismatching bit or an unknown command. Both are visible one cycle after the offending write. A lost bus reset shows as grant_o still high one cycle after the pulse.

// File: rtl/owr_rom_pkg.sv
package owr_rom_pkg;

    localparam int OP_W  = 8;
    localparam int CRC_W = 8;

    localparam logic [OP_W-1:0] OP_READ   = 8'h33;
    localparam logic [OP_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [OP_W-1:0] OP_SKIP   = 8'hCC;
    localparam logic [OP_W-1:0] OP_SEARCH = 8'hF0;
    localparam logic [OP_W-1:0] OP_ALARM  = 8'hEC;

    // reflected form of x^8 + x^5 + x^4 + 1
    localparam logic [CRC_W-1:0] CRC_TAPS = 8'h8C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH_ID,
        ST_SRCH_INV,
        ST_SRCH_DIR,
        ST_GRANT
    } rom_state_e;

    typedef enum logic [2:0] {
        K_READ,
        K_MATCH,
        K_SKIP,
        K_SEARCH,
        K_ALARM,
        K_OTHER
    } rom_kind_e;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc, input logic b);
        logic fb;
        logic [CRC_W-1:0] nx;
        fb = crc[0] ^ b;
        nx = crc >> 1;
        if (fb) nx = nx ^ CRC_TAPS;
        return nx;
    endfunction

endpackage

// File: rtl/owr_id_gen.sv
module owr_id_gen
    import owr_rom_pkg::*;
#(
    parameter int                FAM_W  = 8,
    parameter int                SER_W  = 48,
    parameter logic [FAM_W-1:0]  FAMILY = 8'h10,
    parameter logic [SER_W-1:0]  SERIAL = 48'h0000_0000_0001,
    localparam int               BODY_W = FAM_W + SER_W,
    localparam int               ID_W   = BODY_W + CRC_W
) (
    output logic [ID_W-1:0] id_o
);

    function automatic logic [CRC_W-1:0] body_crc(input logic [BODY_W-1:0] body);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = 0; i < BODY_W; i++) c = crc_step(c, body[i]);
        return c;
    endfunction

    localparam logic [BODY_W-1:0] BODY  = {SERIAL, FAMILY};
    localparam logic [CRC_W-1:0]  CHECK = body_crc(BODY);

    assign id_o = {CHECK, BODY};

endmodule

// File: rtl/owr_cmd_decode.sv
module owr_cmd_decode
    import owr_rom_pkg::*;
(
    input  logic [OP_W-1:0] code_i,
    output rom_kind_e       kind_o
);

    always_comb begin
        unique case (code_i)
            OP_READ:   kind_o = K_READ;
            OP_MATCH:  kind_o = K_MATCH;
            OP_SKIP:   kind_o = K_SKIP;
            OP_SEARCH: kind_o = K_SEARCH;
            OP_ALARM:  kind_o = K_ALARM;
            default:   kind_o = K_OTHER;
        endcase
    end

endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
    import owr_rom_pkg::*;
#(
    parameter int               FAM_W  = 8,
    parameter int               SER_W  = 48,
    parameter logic [FAM_W-1:0] FAMILY = 8'h10,
    parameter logic [SER_W-1:0] SERIAL = 48'h0000_0000_0001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset_i,
    input  logic wr_valid_i,
    input  logic wr_bit_i,
    input  logic rd_done_i,
    input  logic alarm_i,
    output logic tx_valid_o,
    output logic tx_bit_o,
    output logic grant_o
);

    localparam int ID_W    = FAM_W + SER_W + CRC_W;
    localparam int IDX_W   = $clog2(ID_W);
    localparam int OPC_W   = $clog2(OP_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);
    localparam logic [OPC_W-1:0] OPC_LAST = OPC_W'(OP_W - 1);

    typedef struct packed {
        rom_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [OP_W-1:0]   op_sr;
        logic [OPC_W-1:0]  op_cnt;
    } rom_regs_t;

    rom_regs_t r_q, r_d;

    logic [ID_W-1:0] id;
    logic [OP_W-1:0] op_next;
    rom_kind_e       kind;
    logic            id_bit;

    owr_id_gen #(
        .FAM_W  (FAM_W),
        .SER_W  (SER_W),
        .FAMILY (FAMILY),
        .SERIAL (SERIAL)
    ) u_id (
        .id_o (id)
    );

    // command arrives lsb first: new bit enters at the top
    assign op_next = {wr_bit_i, r_q.op_sr[OP_W-1:1]};
    assign id_bit  = id[r_q.idx];

    owr_cmd_decode u_dec (
        .code_i (op_next),
        .kind_o (kind)
    );

    always_comb begin
        r_d        = r_q;
        tx_valid_o = 1'b0;
        tx_bit_o   = 1'b0;
        grant_o    = (r_q.state == ST_GRANT);

        unique case (r_q.state)
            ST_READ, ST_SRCH_ID: begin
                tx_valid_o = 1'b1;
                tx_bit_o   = id_bit;
            end
            ST_SRCH_INV: begin
                tx_valid_o = 1'b1;
                tx_bit_o   = ~id_bit;
            end
            default: ;
        endcase

        if (bus_reset_i) begin
            r_d.state  = ST_CMD;
            r_d.idx    = '0;
            r_d.op_sr  = '0;
            r_d.op_cnt = '0;
        end else begin
            unique case (r_q.state)
                ST_CMD: if (wr_valid_i) begin
                    r_d.op_sr  = op_next;
                    r_d.op_cnt = r_q.op_cnt + 1'b1;
                    if (r_q.op_cnt == OPC_LAST) begin
                        r_d.idx = '0;
                        unique case (kind)
                            K_READ:   r_d.state = ST_READ;
                            K_MATCH:  r_d.state = ST_MATCH;
                            K_SKIP:   r_d.state = ST_GRANT;
                            K_SEARCH: r_d.state = ST_SRCH_ID;
                            K_ALARM:  r_d.state = alarm_i ? ST_SRCH_ID : ST_IDLE;
                            default:  r_d.state = ST_IDLE;
                        endcase
                    end
                end
                ST_READ: if (rd_done_i) begin
                    if (r_q.idx == IDX_LAST) r_d.state = ST_GRANT;
                    else                     r_d.idx   = r_q.idx + 1'b1;
                end
                ST_MATCH: if (wr_valid_i) begin
                    if (wr_bit_i != id_bit)       r_d.state = ST_IDLE;
                    else if (r_q.idx == IDX_LAST) r_d.state = ST_GRANT;
                    else                          r_d.idx   = r_q.idx + 1'b1;
                end
                ST_SRCH_ID:  if (rd_done_i) r_d.state = ST_SRCH_INV;
                ST_SRCH_INV: if (rd_done_i) r_d.state = ST_SRCH_DIR;
                ST_SRCH_DIR: if (wr_valid_i) begin
                    if (wr_bit_i != id_bit || r_q.idx == IDX_LAST) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.idx   = r_q.idx + 1'b1;
                        r_d.state = ST_SRCH_ID;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.idx    <= '0;
            r_q.op_sr  <= '0;
            r_q.op_cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/owr_rom_layer_chk.sv
module owr_rom_layer_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_reset_i,
    input logic wr_valid_i,
    input logic rd_done_i,
    input logic tx_valid_o,
    input logic tx_bit_o,
    input logic grant_o
);

    // R11
    reset_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> (!grant_o && !tx_valid_o));

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !bus_reset_i) |=> grant_o);

    // R12
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !rd_done_i && !bus_reset_i) |=> (tx_valid_o && $stable(tx_bit_o)));

    // R3
    grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> $past(wr_valid_i || rd_done_i));

    // R6
    grant_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> !tx_valid_o);

endmodule

bind owr_rom_layer owr_rom_layer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset_i (bus_reset_i),
    .wr_valid_i  (wr_valid_i),
    .rd_done_i   (rd_done_i),
    .tx_valid_o  (tx_valid_o),
    .tx_bit_o    (tx_bit_o),
    .grant_o     (grant_o)
);

// File: tb/test_owr_rom_layer.sv
`timescale 1ns/1ps
module test_owr_rom_layer;

    localparam logic [7:0]  T_FAM = 8'h10;
    localparam logic [47:0] T_SER = 48'hA5C3_0F1E_7B29;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset_i = 1'b0, wr_valid_i = 1'b0, wr_bit_i = 1'b0, rd_done_i = 1'b0, alarm_i = 1'b0;
    logic tx_valid_o, tx_bit_o, grant_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] exp_id;

    always #2.5 clk = ~clk;

    owr_rom_layer #(.FAMILY(T_FAM), .SERIAL(T_SER)) i_owr_rom_layer (
        .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .wr_valid_i(wr_valid_i),
        .wr_bit_i(wr_bit_i), .rd_done_i(rd_done_i), .alarm_i(alarm_i),
        .tx_valid_o(tx_valid_o), .tx_bit_o(tx_bit_o), .grant_o(grant_o)
    );

    function automatic logic [7:0] ref_crc(input logic [55:0] body);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic fb = c[0] ^ body[i];
            c = {1'b0, c[7:1]};
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_rst();
        bus_reset_i = 1'b1; @(negedge clk); bus_reset_i = 1'b0;
    endtask

    task automatic wbit(input logic b);
        wr_bit_i = b; wr_valid_i = 1'b1; @(negedge clk); wr_valid_i = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] c);
        for (int i = 0; i < 8; i++) wbit(c[i]);
    endtask

    // value seen by the master: released line reads as 1
    task automatic rbit(output logic v, output logic b);
        v = tx_valid_o; b = tx_valid_o ? tx_bit_o : 1'b1;
        rd_done_i = 1'b1; @(negedge clk); rd_done_i = 1'b0;
    endtask

    task automatic quiet(input string req);
        check(!grant_o && !tx_valid_o, req, {62'd0, grant_o, tx_valid_o}, 64'd0);
    endtask

    // drop < 0: follow own identity all the way
    task automatic run_search(input int drop, input string req);
        logic v1, b1, v2, b2;
        int bad = 0;
        for (int i = 0; i < 64; i++) begin
            rbit(v1, b1);
            rbit(v2, b2);
            if (!(v1 && v2 && b1 == exp_id[i] && b2 == ~exp_id[i])) bad++;
            wbit(i == drop ? ~exp_id[i] : exp_id[i]);
            if (i == drop) break;
        end
        check(bad == 0, req, 64'(bad), 64'd0);
        quiet(req);
        rbit(v1, b1);
        check(!v1 && b1, req, {63'd0, v1}, 64'd0);
    endtask

    initial begin
        logic v, b;
        logic [63:0] got;
        void'($urandom(32'd4711));
        exp_id = {ref_crc({T_SER, T_FAM}), T_SER, T_FAM};
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: quiet after reset, commands ignored before first bus reset
        quiet("R2");
        wbyte(8'hCC);
        quiet("R2");

        // R3 / R1: read identity
        bus_rst();
        wbyte(8'h33);
        got = '0;
        for (int i = 0; i < 64; i++) begin
            rbit(v, b);
            got[i] = b;
        end
        check(got == exp_id, "R3", got, exp_id);
        check(got[7:0] == 8'h10, "R1", {56'd0, got[7:0]}, 64'h10);
        check(got[63:56] == ref_crc(got[55:0]), "R1", {56'd0, got[63:56]}, {56'd0, ref_crc(got[55:0])});
        check(grant_o == 1'b1, "R3", {63'd0, grant_o}, 64'd1);

        // R12: write events during an offer do not advance it
        bus_rst();
        wbyte(8'h33);
        wbit(1'b1); wbit(1'b0); wbit(1'b1);
        rbit(v, b);
        check(v && b == exp_id[0], "R12", {63'd0, b}, {63'd0, exp_id[0]});
        rbit(v, b);
        check(v && b == exp_id[1], "R12", {63'd0, b}, {63'd0, exp_id[1]});

        // R4: full match
        bus_rst();
        wbyte(8'h55);
        for (int i = 0; i < 64; i++) wbit(exp_id[i]);
        check(grant_o == 1'b1, "R4", {63'd0, grant_o}, 64'd1);

        // R5: random single-bit mismatches, including both ends
        for (int k = 0; k < 6; k++) begin
            int pos = (k == 0) ? 0 : (k == 1) ? 63 : int'($urandom_range(0, 63));
            bus_rst();
            wbyte(8'h55);
            for (int i = 0; i < 64; i++) wbit(i == pos ? ~exp_id[i] : exp_id[i]);
            quiet("R5");
            rbit(v, b);
            check(!v, "R5", {63'd0, v}, 64'd0);
        end

        // R6: skip
        bus_rst();
        for (int i = 0; i < 7; i++) wbit(8'hCC >> i);
        check(grant_o == 1'b0, "R6", {63'd0, grant_o}, 64'd0);
        wbit(1'b1);
        check(grant_o && !tx_valid_o, "R6", {62'd0, grant_o, tx_valid_o}, 64'd2);

        // R11: bus reset from granted state and mid-match
        bus_rst();
        quiet("R11");
        wbyte(8'h55);
        for (int i = 0; i < 20; i++) wbit(exp_id[i]);
        bus_rst();
        wbyte(8'hCC);
        check(grant_o == 1'b1, "R11", {63'd0, grant_o}, 64'd1);

        // R7: full search pass
        bus_rst();
        wbyte(8'hF0);
        run_search(-1, "R7");

        // R8: random drop-out positions
        for (int k = 0; k < 5; k++) begin
            int pos = (k == 0) ? 63 : int'($urandom_range(0, 62));
            bus_rst();
            wbyte(8'hF0);
            run_search(pos, "R8");
        end

        // R9: alarm search with and without alarm
        alarm_i = 1'b1;
        bus_rst();
        wbyte(8'hEC);
        run_search(-1, "R9");
        alarm_i = 1'b0;
        bus_rst();
        wbyte(8'hEC);
        quiet("R9");
        rbit(v, b);
        check(!v, "R9", {63'd0, v}, 64'd0);

        // R10: random unknown commands
        for (int k = 0; k < 8; k++) begin
            logic [7:0] c;
            do c = 8'($urandom);
            while (c == 8'h33 || c == 8'h55 || c == 8'hCC || c == 8'hF0 || c == 8'hEC);
            bus_rst();
            wbyte(c);
            quiet("R10");
            wbyte(8'hCC);
            rbit(v, b);
            quiet("R10");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule